// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting timer channel. A single-cycle count enable, derived from the system clock, advances it, so the whole channel sits in one clock domain. A load strobe supplies a new initial count together with a 3-bit waveform mode and a decimal-count flag. The channel drives one output pin whose waveform depends on the mode:
- a level that rises at terminal count (modes 0 and 1);
- a rate generator with one low tick per period (modes 2 and 6);
- a square wave (modes 3 and 7);
- a single low strobe at terminal count (modes 4 and 5).

The current count is always visible on a port, so that the register interface next to it can latch the value and return it to software.

Counting can run in plain binary or as four packed decimal digits. An initial count of zero stands for the full range of the selected format. A gate input pauses counting while it is low. A rising edge on the gate re-arms the channel, so the next count tick reloads the initial count. A new load also re-arms the channel and drops any period that is in progress. The mode and format it carries replace the old ones together. Byte sequencing, latching and read-back live in the register interface, not in this block.

Top module: `pit_channel`

## Requirements
- R1: After reset the count is 0, the mode is 0 and the output is low.
- R2: A load never changes the count directly. The first count tick after the load (with the gate high) copies the initial count into the count. Each later tick decrements it by one.
- R3: In decimal mode (flag = 1) each 4-bit nibble of the count is one decimal digit, least significant nibble first, and 0x0000 decrements to 0x9999. In binary mode 0x0000 decrements to 0xFFFF.
- R4: An initial count of 0 acts as the full range: 65536 ticks in binary and 10000 in decimal. In mode 3 with a decimal zero load, the output is high for 5000 ticks and low for 5000 ticks of each period.
- R5: In modes 0 and 1 the output is low while counting. It goes high on the tick where the count goes from 1 to 0. It stays high while the counter keeps wrapping, until the next load.
- R6: In modes 2 and 6 the output is low exactly while the count equals 1. The next tick reloads the initial count and the output returns high.
- R7: In modes 3 and 7 the output is high while the count is greater than half the initial count (rounded down) and low otherwise. An odd count N therefore gives (N+1)/2 high ticks and (N-1)/2 low ticks.
- R8: In modes 4 and 5 the output is high. It goes low for exactly one tick when the count goes from 1 to 0, and it does not pulse again when the count later wraps back to 0.
- R9: While counting has not started, or while the gate is low, the output is high in every mode except mode 0, where it is low.
- R10: While the gate is low, count ticks do not change the count. After a rising gate edge, the next tick reloads the initial count.
- R11: Modes 6 and 7 behave as modes 2 and 3. Mode bit 1 set means periodic reload.
- R12: A load issued while counting abandons the current period. The count holds until the next tick, which loads the new value in the new mode.
- R13: Clock cycles without a count tick leave the count and the output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count enable, one cycle per count tick |
| gate | input | 1 | Counting enable; a rising edge restarts the count |
| mode_sel | input | 3 | Waveform mode taken on load |
| bcd_sel | input | 1 | 1 = four-digit decimal count, 0 = binary |
| load_strb | input | 1 | Single-cycle strobe that takes a new initial count |
| load_count | input | 16 | Initial count (zero = full range) |
| count_q | output | 16 | Current count value |
| wave_out | output | 1 | Timer output pin |

## Verification
Full-range behaviour is the hardest thing to reach from the ports. The square-wave balance of a zero load, and the absence of a second strobe after the counter wraps back to zero, each take ten thousand ticks or more before anything shows. The bench reaches these cases with decimal-mode zero and small loads, whose wrap period is 10000 ticks rather than 65536. It then walks the whole period tick by tick, counting the high or low output ticks and checking the totals. Gate pause and restart, and a reload in the middle of a period, are set up by directed sequences. The tick-level timing of every mode comes from a vector table.

// File: rtl/pit_pkg.sv
package pit_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      WK_LEVEL  = 2'd0,
      WK_RATE   = 2'd1,
      WK_SQUARE = 2'd2,
      WK_STROBE = 2'd3
   } wave_kind_t;

   function automatic wave_kind_t kind_of(input logic [MODE_W-1:0] m);
      if (m[1])      return m[0] ? WK_SQUARE : WK_RATE;
      else if (m[2]) return WK_STROBE;
      else           return WK_LEVEL;
   endfunction

   function automatic bit nibbles_decimal(input logic [15:0] v);
      bit ok;
      ok = 1'b1;
      for (int d = 0; d < 4; d++) if (v[4*d +: 4] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/pit_count_core.sv
module pit_count_core #(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             dec,
   input  logic             bcd,
   input  logic [CNT_W-1:0] ld_val,
   output logic [CNT_W-1:0] q
);
   localparam int DIGITS = CNT_W / 4;
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   logic [CNT_W-1:0] q_r;
   logic [CNT_W-1:0] bin_next;
   logic [CNT_W-1:0] bcd_next;
   logic [CNT_W-1:0] all_nines;
   logic             use_bcd;

   assign bin_next = q_r - CNT_W'(1);

   generate
      if (BCD_EN) begin : g_bcd
         logic [DIGITS-1:0] borrow;
         assign borrow[0] = 1'b1;
         for (genvar d = 0; d < DIGITS; d++) begin : g_dig
            logic [3:0] cur;
            assign cur = q_r[4*d +: 4];
            assign bcd_next[4*d +: 4] = borrow[d] ? ((cur == 4'd0) ? 4'd9 : cur - 4'd1) : cur;
            assign all_nines[4*d +: 4] = 4'd9;
            if (d + 1 < DIGITS) begin : g_chain
               assign borrow[d+1] = borrow[d] && (cur == 4'd0);
            end
         end
         assign use_bcd = bcd;
      end else begin : g_bin
         assign bcd_next  = bin_next;
         assign all_nines = ALL_ONES;
         assign use_bcd   = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   q_r <= '0;
      else if (ld)  q_r <= ld_val;
      else if (dec) q_r <= use_bcd ? bcd_next : bin_next;
   end

   assign q = q_r;

   // R3: a decrement from zero lands on the top of the selected range
   a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !ld && q_r == '0) |=> (q_r == ($past(use_bcd) ? all_nines : ALL_ONES)));

endmodule

// File: rtl/pit_wave_sel.sv
module pit_wave_sel
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic [MODE_W-1:0] mode,
   input  logic              bcd,
   input  logic              active,
   input  logic              fired,
   input  logic              pulse,
   input  logic [CNT_W-1:0]  count,
   input  logic [CNT_W-1:0]  init,
   output logic              wave_out
);
   localparam int DIGITS = CNT_W / 4;
   localparam int MAG_W  = CNT_W + 1;
   localparam logic [MAG_W-1:0] BIN_FULL = {1'b1, {CNT_W{1'b0}}};
   localparam logic [MAG_W-1:0] DEC_FULL = MAG_W'(10 ** DIGITS);

   logic             is_dec;
   logic [MAG_W-1:0] cur_mag;
   logic [MAG_W-1:0] init_mag;
   wave_kind_t       kind;

   assign is_dec = BCD_EN && bcd;
   assign kind   = kind_of(mode);

   function automatic logic [MAG_W-1:0] to_mag(input logic [CNT_W-1:0] v, input logic dec_fmt);
      logic [MAG_W-1:0] acc;
      logic [MAG_W-1:0] weight;
      if (v == '0) return dec_fmt ? DEC_FULL : BIN_FULL;
      if (!dec_fmt) return {1'b0, v};
      acc    = '0;
      weight = MAG_W'(1);
      for (int d = 0; d < DIGITS; d++) begin
         acc    = acc + MAG_W'(v[4*d +: 4]) * weight;
         weight = weight * MAG_W'(10);
      end
      return acc;
   endfunction

   assign cur_mag  = to_mag(count, is_dec);
   assign init_mag = to_mag(init, is_dec);

   always_comb begin
      if (!active) begin
         wave_out = (mode != '0);
      end else begin
         unique case (kind)
            WK_LEVEL:  wave_out = fired;
            WK_RATE:   wave_out = (count != CNT_W'(1));
            WK_SQUARE: wave_out = (cur_mag > (init_mag >> 1));
            default:   wave_out = !pulse;
         endcase
      end
   end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter bit BCD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic              gate,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic              bcd_sel,
   input  logic              load_strb,
   input  logic [CNT_W-1:0]  load_count,
   output logic [CNT_W-1:0]  count_q,
   output logic              wave_out
);
   generate
      if (CNT_W < 4 || (CNT_W % 4) != 0) begin : g_bad_width
         $error("pit_channel: CNT_W must be a positive multiple of 4");
      end
   endgenerate

   logic [CNT_W-1:0]  init_r;
   logic [MODE_W-1:0] mode_r;
   logic              bcd_r;
   logic              armed;
   logic              running;
   logic              fired;
   logic              pulse;
   logic              gate_q;

   logic gate_rise;
   logic step;
   logic periodic;
   logic at_one;
   logic core_ld;
   logic core_dec;

   assign gate_rise = gate && !gate_q;
   assign step      = cnt_tick && gate && !load_strb && !gate_rise;
   assign periodic  = mode_r[1];
   assign at_one    = (count_q == CNT_W'(1));
   assign core_ld   = step && (armed || (running && periodic && at_one));
   assign core_dec  = step && running && !core_ld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_r  <= '0;
         mode_r  <= '0;
         bcd_r   <= 1'b0;
         armed   <= 1'b0;
         running <= 1'b0;
         fired   <= 1'b0;
         pulse   <= 1'b0;
         gate_q  <= 1'b0;
      end else begin
         gate_q <= gate;
         if (load_strb) begin
            init_r  <= load_count;
            mode_r  <= mode_sel;
            bcd_r   <= bcd_sel;
            armed   <= 1'b1;
            running <= 1'b0;
            fired   <= 1'b0;
            pulse   <= 1'b0;
         end else if (gate_rise) begin
            armed   <= 1'b1;
            running <= 1'b0;
            fired   <= 1'b0;
            pulse   <= 1'b0;
         end else if (step) begin
            pulse <= 1'b0;
            if (armed) begin
               armed   <= 1'b0;
               running <= 1'b1;
            end else if (running && !periodic && at_one && !fired) begin
               fired <= 1'b1;
               pulse <= 1'b1;
            end
         end
      end
   end

   pit_count_core #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (core_ld),
      .dec    (core_dec),
      .bcd    (bcd_r),
      .ld_val (init_r),
      .q      (count_q)
   );

   pit_wave_sel #(.CNT_W(CNT_W), .BCD_EN(BCD_EN)) u_wave (
      .mode     (mode_r),
      .bcd      (bcd_r),
      .active   (running && gate),
      .fired    (fired),
      .pulse    (pulse),
      .count    (count_q),
      .init     (init_r),
      .wave_out (wave_out)
   );

   // R2: a load only arms the channel; counting waits for a tick
   a_r2_start_delay: assert property (@(posedge clk) disable iff (!rst_n)
      load_strb |=> (armed && !running));

   // R10: a rising gate re-arms the channel
   a_r10_gate_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (gate && !gate_q && !load_strb) |=> (armed && !running));

   // R9: idle output level
   a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!running || !gate) |-> (wave_out == (mode_r != '0)));

   // R5: level modes stay low until terminal count
   a_r5_level_low: assert property (@(posedge clk) disable iff (!rst_n)
      (running && gate && !mode_r[2] && !mode_r[1] && !fired) |-> !wave_out);

   // R6: rate mode reloads the initial count after the count of one
   a_r6_rate_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (running && mode_r[1] && at_one && cnt_tick && gate && gate_q && !load_strb) |=> (count_q == init_r));

   // R8: strobe lasts a single tick
   a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && cnt_tick && gate && gate_q && !load_strb) |=> !pulse);

   // R3: decimal counting keeps every nibble a valid digit
   a_r3_digits_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (BCD_EN && CNT_W == 16 && running && bcd_r && nibbles_decimal(16'(init_r))) |-> nibbles_decimal(16'(count_q)));

endmodule

// File: tb/pit_channel_test.sv
`timescale 1ns/1ps
module pit_channel_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0;
   logic        gate = 1'b1;
   logic [2:0]  mode_sel = '0;
   logic        bcd_sel = 1'b0;
   logic        load_strb = 1'b0;
   logic [15:0] load_count = '0;
   logic [15:0] count_q;
   logic        wave_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   pit_channel uut (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate(gate),
      .mode_sel(mode_sel), .bcd_sel(bcd_sel), .load_strb(load_strb),
      .load_count(load_count), .count_q(count_q), .wave_out(wave_out)
   );

   typedef struct packed {
      logic [2:0]  mode;
      logic        bcd;
      logic [15:0] init;
      logic [7:0]  ticks;
      logic        chk_cnt;
      logic [15:0] exp_cnt;
      logic        exp_out;
      logic [7:0]  req;
   } vec_t;

   localparam int N_VEC = 21;
   localparam vec_t VECS [N_VEC] = '{
      '{3'd0, 1'b0, 16'h0005, 8'd1, 1'b1, 16'h0005, 1'b0, 8'd2},  // R2 first tick copies
      '{3'd0, 1'b0, 16'h0005, 8'd3, 1'b1, 16'h0003, 1'b0, 8'd2},  // R2 decrement
      '{3'd0, 1'b0, 16'h0005, 8'd6, 1'b1, 16'h0000, 1'b1, 8'd5},  // R5 terminal
      '{3'd0, 1'b0, 16'h0005, 8'd7, 1'b1, 16'hFFFF, 1'b1, 8'd5},  // R5 stays high past wrap
      '{3'd1, 1'b0, 16'h0003, 8'd2, 1'b1, 16'h0002, 1'b0, 8'd5},  // R5 mode 1 low
      '{3'd0, 1'b1, 16'h0010, 8'd2, 1'b1, 16'h0009, 1'b0, 8'd3},  // R3 digit borrow
      '{3'd0, 1'b1, 16'h0000, 8'd2, 1'b1, 16'h9999, 1'b0, 8'd3},  // R3 decimal wrap
      '{3'd0, 1'b0, 16'h0000, 8'd2, 1'b1, 16'hFFFF, 1'b0, 8'd4},  // R4 binary full range
      '{3'd2, 1'b0, 16'h0004, 8'd4, 1'b1, 16'h0001, 1'b0, 8'd6},  // R6 low at one
      '{3'd2, 1'b0, 16'h0004, 8'd5, 1'b1, 16'h0004, 1'b1, 8'd6},  // R6 reload
      '{3'd3, 1'b0, 16'h0005, 8'd3, 1'b1, 16'h0003, 1'b1, 8'd7},  // R7 high half
      '{3'd3, 1'b0, 16'h0005, 8'd4, 1'b1, 16'h0002, 1'b0, 8'd7},  // R7 low half
      '{3'd3, 1'b0, 16'h0005, 8'd6, 1'b1, 16'h0005, 1'b1, 8'd7},  // R7 reload
      '{3'd4, 1'b0, 16'h0003, 8'd4, 1'b1, 16'h0000, 1'b0, 8'd8},  // R8 strobe low
      '{3'd4, 1'b0, 16'h0003, 8'd5, 1'b1, 16'hFFFF, 1'b1, 8'd8},  // R8 back high
      '{3'd5, 1'b1, 16'h0002, 8'd3, 1'b1, 16'h0000, 1'b0, 8'd8},  // R8 mode 5 decimal
      '{3'd6, 1'b0, 16'h0003, 8'd3, 1'b1, 16'h0001, 1'b0, 8'd11}, // R11 mode 6 as 2
      '{3'd7, 1'b0, 16'h0004, 8'd3, 1'b1, 16'h0002, 1'b0, 8'd11}, // R11 mode 7 as 3
      '{3'd1, 1'b0, 16'h0003, 8'd0, 1'b0, 16'h0000, 1'b1, 8'd9},  // R9 not started, mode 1
      '{3'd0, 1'b0, 16'h0007, 8'd0, 1'b0, 16'h0000, 1'b0, 8'd9},  // R9 not started, mode 0
      '{3'd2, 1'b1, 16'h0003, 8'd3, 1'b1, 16'h0001, 1'b0, 8'd6}   // R6 decimal rate
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_load(input logic [2:0] m, input logic b, input logic [15:0] v);
      @(negedge clk);
      load_strb = 1'b1; mode_sel = m; bcd_sel = b; load_count = v;
      @(negedge clk);
      load_strb = 1'b0;
   endtask

   task automatic do_tick();
      @(negedge clk);
      cnt_tick = 1'b1;
      @(negedge clk);
      cnt_tick = 1'b0;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int cnt_hi;
      int cnt_lo;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 count", 32'(count_q), 32'h0);
      check("R1 out", 32'(wave_out), 32'h0);

      for (int i = 0; i < N_VEC; i++) begin
         do_load(VECS[i].mode, VECS[i].bcd, VECS[i].init);
         for (int t = 0; t < int'(VECS[i].ticks); t++) do_tick();
         if (VECS[i].chk_cnt)
            check($sformatf("R%0d vec%0d count", VECS[i].req, i), 32'(count_q), 32'(VECS[i].exp_cnt));
         check($sformatf("R%0d vec%0d out", VECS[i].req, i), 32'(wave_out), 32'(VECS[i].exp_out));
      end

      // R13: no tick, nothing moves
      do_load(3'd0, 1'b0, 16'h0009);
      do_tick();
      repeat (5) @(negedge clk);
      check("R13 count held", 32'(count_q), 32'h9);
      check("R13 out held", 32'(wave_out), 32'h0);

      // R9 / R10: gate pause and restart in mode 2
      do_load(3'd2, 1'b0, 16'd10);
      repeat (3) do_tick();
      check("R10 before pause", 32'(count_q), 32'd8);
      @(negedge clk); gate = 1'b0;
      @(negedge clk);
      check("R9 gate low mode 2 out", 32'(wave_out), 32'h1);
      repeat (2) do_tick();
      check("R10 paused count", 32'(count_q), 32'd8);
      @(negedge clk); gate = 1'b1;
      @(negedge clk);
      do_tick();
      check("R10 restart reload", 32'(count_q), 32'd10);

      // R9: mode 0 after terminal, gate low gives low
      do_load(3'd0, 1'b0, 16'd2);
      repeat (3) do_tick();
      check("R5 mode 0 high", 32'(wave_out), 32'h1);
      @(negedge clk); gate = 1'b0;
      @(negedge clk);
      check("R9 gate low mode 0 out", 32'(wave_out), 32'h0);
      @(negedge clk); gate = 1'b1;
      @(negedge clk);

      // R12: reload abandons period
      do_load(3'd0, 1'b0, 16'd100);
      repeat (3) do_tick();
      check("R12 before reload", 32'(count_q), 32'd98);
      do_load(3'd4, 1'b0, 16'd7);
      check("R12 count held after load", 32'(count_q), 32'd98);
      check("R12 idle out mode 4", 32'(wave_out), 32'h1);
      do_tick();
      check("R12 new count", 32'(count_q), 32'd7);

      // R4: decimal zero in mode 3, full 10000-tick period
      do_load(3'd3, 1'b1, 16'h0000);
      cnt_hi = 0;
      for (int t = 0; t < 10000; t++) begin
         do_tick();
         if (wave_out) cnt_hi++;
      end
      check("R4 square high ticks", 32'(cnt_hi), 32'd5000);
      check("R4 count at period end", 32'(count_q), 32'h1);
      do_tick();
      check("R4 reload to zero", 32'(count_q), 32'h0);

      // R8: strobe does not repeat after decimal wrap
      do_load(3'd4, 1'b1, 16'h0002);
      cnt_lo = 0;
      for (int t = 0; t < 10003; t++) begin
         do_tick();
         if (!wave_out) cnt_lo++;
      end
      check("R8 single strobe", 32'(cnt_lo), 32'd1);
      check("R8 count back at zero", 32'(count_q), 32'h0);

      // R5: mode 1 output stays high through a whole wrap
      do_load(3'd1, 1'b1, 16'h0001);
      repeat (2) do_tick();
      check("R5 mode 1 terminal", 32'(wave_out), 32'h1);
      cnt_lo = 0;
      for (int t = 0; t < 10000; t++) begin
         do_tick();
         if (!wave_out) cnt_lo++;
      end
      check("R5 no low after wrap", 32'(cnt_lo), 32'd0);
      check("R3 decimal wrap period", 32'(count_q), 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule